// File: doc/BRIEF.md
# ISI-Filtering Bang-Bang Phase Detector

This block is the timing-error detector of a deserialized digital clock-recovery loop. Each logic cycle it takes a parallel word of received bits. For every bit it receives four samples: the decision against the zero threshold, the edge sample that follows the bit, and two more decisions taken against a positive and a negative offset threshold. From these it forms one net early-minus-late vote for the loop filter, and a count of the transitions that took part in that vote.

In filtered mode a transition votes only when the data pattern around it suggests little intersymbol interference. The bit before the crossing must repeat the bit that leads into it. The bit after the crossing must repeat the bit that leads out of it. Both bits next to the crossing must be strong enough that the offset-threshold decisions agree with the zero-threshold decision. Crossings that follow long runs sit at a different phase from crossings in busy patterns. Dropping them removes the static lock offset that heavy data-dependent jitter would otherwise cause. In plain mode every transition votes, as a classic bang-bang detector does.

A judgement on a transition may need up to two bits of the next word. So each word is evaluated one cycle late, when the next word is present. Bit 0 of every word is the earliest bit in time.

Top module: `isi_bbpd`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `vote_o` and `nval_o` are 0. The stored history also resets to all-zero bits.
- R2: The result for the word presented at clock edge k is registered at edge k+1, the edge that samples the following word.
- R3: A transition exists between consecutive bits b[n] and b[n+1] when they differ. This includes the pair formed by the last bit of one word and bit 0 of the next. A pair without a transition never votes and is never counted.
- R4: A voting transition whose edge sample `edg_i[n]` equals b[n] is a late vote (-1). If the edge sample equals b[n+1], it is an early vote (+1).
- R5: With `filt_en`=1, a transition votes only if b[n-1]==b[n] and b[n+2]==b[n+1].
- R6: With `filt_en`=1, a transition also needs `thp_i` and `thn_i` to equal `dat_i` at both bit n and bit n+1.
- R7: With `filt_en`=0, every transition votes and the threshold decisions have no effect. The mode applies to the word that is evaluated at the same edge.
- R8: `vote_o` is the signed two's-complement count of early votes minus late votes, and `nval_o` is the number of voting transitions. Therefore |`vote_o`| <= `nval_o` and both have the same parity.
- R9: The look-back and look-ahead bits reach across word boundaries. Bit -1 of a word is the last bit of the previous word, and bits W and W+1 are bits 0 and 1 of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, one word per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_en | input | 1 | 1 = pattern/threshold filtering, 0 = every transition votes |
| dat_i | input | W | Zero-threshold bit decisions, bit 0 earliest |
| edg_i | input | W | Edge sample taken after each bit |
| thp_i | input | W | Bit decisions against the positive offset threshold |
| thn_i | input | W | Bit decisions against the negative offset threshold |
| vote_o | output | $clog2(W)+2 | Signed early-minus-late sum |
| nval_o | output | $clog2(W+1) | Number of voting transitions |

## Verification
The bench goes after the word seam. If the one-bit look-back or the two-bit look-ahead across words is dropped, the transition between words is lost or judged on stale bits, and the boundary-only stimulus gives a count of 0 instead of 1. Alternating data is the worst case for the run filter: a design that skips the run check reports W votes in filtered mode, where 0 is correct. A single weak bit next to one crossing must remove exactly that crossing. A design that checks thresholds on the wrong bits removes a different crossing, or none, and the count is off by one. A long sweep of sparse threshold errors in both modes also catches a swapped early/late sign, a vote that lands a cycle late, and a mode switch that is applied to the wrong word.

// File: rtl/isi_bbpd_pkg.sv
// Shared types for the ISI-filtering phase detector.
// Assumes nothing beyond the synthesizable subset.
package isi_bbpd_pkg;

    // Result of judging one bit-to-bit pair.
    typedef struct packed {
        logic trans;   // the two bits differ
        logic valid;   // the pair takes part in the vote
        logic early;   // edge sample matched the later bit
        logic late;    // edge sample matched the earlier bit
    } lane_vote_t;

endpackage

// File: rtl/isi_bbpd_hist.sv
// Word history for the phase detector.
// Holds the previous word of every sample stream, and the last data bit of
// the word before it. It presents an extended data window that runs from
// bit -1 of the held word up to bit W+1 (bits 0 and 1 of the live word).
// Assumes W >= 2 and one word per clock.
module isi_bbpd_hist #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   dat_i,
    input  logic [W-1:0]   edg_i,
    input  logic [W-1:0]   thp_i,
    input  logic [W-1:0]   thn_i,
    output logic [W+2:0]   win_d,
    output logic [W+1:1]   win_p,
    output logic [W+1:1]   win_n,
    output logic [W-1:0]   win_e
);

    logic [W-1:0] held_d;
    logic [W-1:0] held_e;
    logic [W-1:0] held_p;
    logic [W-1:0] held_n;
    logic         tail_d;

    // Capture the live word and keep the last data bit of the displaced word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_d <= '0;
            held_e <= '0;
            held_p <= '0;
            held_n <= '0;
            tail_d <= 1'b0;
        end else begin
            held_d <= dat_i;
            held_e <= edg_i;
            held_p <= thp_i;
            held_n <= thn_i;
            tail_d <= held_d[W-1];
        end
    end

    // Window index j holds bit j-1 of the held word.
    assign win_d = {dat_i[1:0], held_d, tail_d};
    assign win_p = {thp_i[0], held_p};
    assign win_n = {thn_i[0], held_n};
    assign win_e = held_e;

endmodule

// File: rtl/isi_bbpd_lane.sv
// Judges one bit-to-bit pair.
// Inputs are the bit before the pair (lb), the pair (a then b), the bit
// after it (la), the offset-threshold decisions on a and b, and the edge
// sample between a and b. Purely combinational.
module isi_bbpd_lane
    import isi_bbpd_pkg::*;
(
    input  logic       lb,
    input  logic       a,
    input  logic       b,
    input  logic       la,
    input  logic       pa,
    input  logic       na,
    input  logic       pb,
    input  logic       nb,
    input  logic       e,
    input  logic       filt,
    output lane_vote_t v
);

    logic runs_ok;
    logic lvl_ok;

    // Decide whether the pair votes and in which direction.
    always_comb begin
        runs_ok = (lb == a) && (la == b);
        lvl_ok  = (pa == a) && (na == a) && (pb == b) && (nb == b);
        v.trans = a ^ b;
        v.valid = v.trans && (!filt || (runs_ok && lvl_ok));
        v.early = v.valid && (e == b);
        v.late  = v.valid && (e == a);
    end

endmodule

// File: rtl/isi_bbpd_tally.sv
// Sums the per-pair votes of one word.
// Produces early-minus-late as a signed value and the number of voting
// pairs. Assumes SUM_W >= CNT_W + 1.
module isi_bbpd_tally
    import isi_bbpd_pkg::*;
#(
    parameter  int W     = 64,
    localparam int SUM_W = $clog2(W) + 2,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  lane_vote_t [W-1:0]      lv,
    output logic signed [SUM_W-1:0] sum,
    output logic [CNT_W-1:0]        cnt
);

    logic [CNT_W-1:0]     n_early;
    logic [CNT_W-1:0]     n_late;
    logic signed [CNT_W:0] diff;

    // Population counts of early, late and voting pairs, then the net sum.
    always_comb begin
        n_early = '0;
        n_late  = '0;
        cnt     = '0;
        for (int i = 0; i < W; i++) begin
            n_early = n_early + CNT_W'(lv[i].early);
            n_late  = n_late  + CNT_W'(lv[i].late);
            cnt     = cnt     + CNT_W'(lv[i].valid);
        end
        diff = $signed({1'b0, n_early}) - $signed({1'b0, n_late});
        sum  = SUM_W'(diff);
    end

endmodule

// File: rtl/isi_bbpd.sv
// ISI-filtering bang-bang phase detector, top level.
// Each word is judged once the next word arrives, so that the two look-ahead
// bits exist. The registered outputs carry the result for the previous word.
// Assumes W >= 2, bit 0 is the earliest bit and edg_i[n] is sampled
// between bit n and bit n+1.
module isi_bbpd
    import isi_bbpd_pkg::*;
#(
    parameter  int W     = 64,
    localparam int SUM_W = $clog2(W) + 2,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    filt_en,
    input  logic [W-1:0]            dat_i,
    input  logic [W-1:0]            edg_i,
    input  logic [W-1:0]            thp_i,
    input  logic [W-1:0]            thn_i,
    output logic signed [SUM_W-1:0] vote_o,
    output logic [CNT_W-1:0]        nval_o
);

    logic [W+2:0]        win_d;
    logic [W+1:1]        win_p;
    logic [W+1:1]        win_n;
    logic [W-1:0]        win_e;
    lane_vote_t [W-1:0]  lv;
    logic [W-1:0]        trans_v;
    logic [W-1:0]        valid_v;
    logic signed [SUM_W-1:0] sum_c;
    logic [CNT_W-1:0]    cnt_c;

    isi_bbpd_hist #(.W(W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .dat_i (dat_i),
        .edg_i (edg_i),
        .thp_i (thp_i),
        .thn_i (thn_i),
        .win_d (win_d),
        .win_p (win_p),
        .win_n (win_n),
        .win_e (win_e)
    );

    // One judge per pair of the held word; pair i joins bit i and bit i+1.
    for (genvar i = 0; i < W; i++) begin : g_lane
        isi_bbpd_lane u_lane (
            .lb   (win_d[i]),
            .a    (win_d[i+1]),
            .b    (win_d[i+2]),
            .la   (win_d[i+3]),
            .pa   (win_p[i+1]),
            .na   (win_n[i+1]),
            .pb   (win_p[i+2]),
            .nb   (win_n[i+2]),
            .e    (win_e[i]),
            .filt (filt_en),
            .v    (lv[i])
        );
        assign trans_v[i] = lv[i].trans;
        assign valid_v[i] = lv[i].valid;
    end

    isi_bbpd_tally #(.W(W)) u_tally (
        .lv  (lv),
        .sum (sum_c),
        .cnt (cnt_c)
    );

    // Register the word result for the loop filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_o <= '0;
            nval_o <= '0;
        end else begin
            vote_o <= sum_c;
            nval_o <= cnt_c;
        end
    end

endmodule

// File: rtl/isi_bbpd_chk.sv
// Property checker for isi_bbpd, attached with bind.
// Watches the registered outputs and the pair vectors between the lanes
// and the tally.
module isi_bbpd_chk #(
    parameter  int W     = 64,
    localparam int SUM_W = $clog2(W) + 2,
    localparam int CNT_W = $clog2(W + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    filt_en,
    input logic signed [SUM_W-1:0] vote_o,
    input logic [CNT_W-1:0]        nval_o,
    input logic [W-1:0]            trans_v,
    input logic [W-1:0]            valid_v
);

    int vote_abs;

    // Magnitude of the signed vote for the bound check.
    always_comb begin
        vote_abs = int'(vote_o);
        if (vote_abs < 0) vote_abs = -vote_abs;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (vote_o == '0 && nval_o == '0));

    // R8
    vote_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_abs <= int'(nval_o));

    // R8
    vote_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_o[0] == nval_o[0]);

    // R5
    filt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_v & ~trans_v) == 0);

    // R7
    plain_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |-> (valid_v == trans_v));

endmodule

bind isi_bbpd isi_bbpd_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt_en (filt_en),
    .vote_o  (vote_o),
    .nval_o  (nval_o),
    .trans_v (trans_v),
    .valid_v (valid_v)
);

// File: tb/sim_isi_bbpd.sv
// Bench for isi_bbpd on an 8-bit word: directed patterns plus a long sweep,
// with the expected result recomputed from the requirements.
module sim_isi_bbpd;

    localparam int W       = 8;
    localparam int SUM_W   = $clog2(W) + 2;
    localparam int CNT_W   = $clog2(W + 1);
    localparam int CLK_P   = 10;
    localparam int WD_MAX  = 100000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    filt_en = 1'b1;
    logic [W-1:0]            dat_i = '0;
    logic [W-1:0]            edg_i = '0;
    logic [W-1:0]            thp_i = '0;
    logic [W-1:0]            thn_i = '0;
    logic signed [SUM_W-1:0] vote_o;
    logic [CNT_W-1:0]        nval_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // Model state: the held word and the bit before it.
    logic [W-1:0] m_d = '0, m_e = '0, m_p = '0, m_n = '0;
    logic         m_tail = 1'b0;

    isi_bbpd #(.W(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .filt_en (filt_en),
        .dat_i   (dat_i),
        .edg_i   (edg_i),
        .thp_i   (thp_i),
        .thn_i   (thn_i),
        .vote_o  (vote_o),
        .nval_o  (nval_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_MAX && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected < %0d", cyc, WD_MAX);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic void expect_of(input logic [W-1:0] cd, cp, cn,
                                      input logic f,
                                      output int ev, output int ec);
        int bits[W+3];
        int hp[W+3];
        int hn[W+3];
        ev = 0;
        ec = 0;
        bits[0] = int'(m_tail);
        for (int k = 0; k < W; k++) begin
            bits[k+1] = int'(m_d[k]);
            hp[k+1]   = int'(m_p[k]);
            hn[k+1]   = int'(m_n[k]);
        end
        bits[W+1] = int'(cd[0]);
        bits[W+2] = int'(cd[1]);
        hp[W+1]   = int'(cp[0]);
        hn[W+1]   = int'(cn[0]);
        hp[0] = 0; hn[0] = 0; hp[W+2] = 0; hn[W+2] = 0;
        for (int n = 0; n < W; n++) begin
            int a, b;
            bit ok;
            a = bits[n+1];
            b = bits[n+2];
            if (a == b) continue;
            ok = 1;
            if (f) begin
                if (bits[n] != a || bits[n+3] != b) ok = 0;
                if (hp[n+1] != a || hn[n+1] != a) ok = 0;
                if (hp[n+2] != b || hn[n+2] != b) ok = 0;
            end
            if (!ok) continue;
            ec++;
            if (int'(m_e[n]) == b) ev++;
            else ev--;
        end
    endfunction

    task automatic check(input string tag, input int ev, input int ec);
        n_run++;
        if (int'(vote_o) != ev || int'(nval_o) != ec) begin
            n_fail++;
            $display("FAIL %s: actual vote %0d count %0d expected vote %0d count %0d",
                     tag, int'(vote_o), int'(nval_o), ev, ec);
        end
    endtask

    // Present one word, then check the result that lands at the next edge.
    task automatic step(input logic [W-1:0] d, e, p, n, input logic f,
                        input string tag);
        int ev, ec;
        @(negedge clk);
        dat_i = d; edg_i = e; thp_i = p; thn_i = n; filt_en = f;
        expect_of(d, p, n, f, ev, ec);
        @(posedge clk);
        #1;
        check(tag, ev, ec);
        m_tail = m_d[W-1];
        m_d = d; m_e = e; m_p = p; m_n = n;
    endtask

    initial begin
        logic [W-1:0] pat, bad;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h00, 8'h80, 8'h00, 8'h00, 1'b1, "R1 first word");

        // R9: boundary-only transition, early by the last edge sample
        step(8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, "R9 seam");
        check("R9 seam literal", 1, 1);

        // R3: steady ones, nothing to vote on
        step(8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, "R3 flat");
        step(8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, "R3 flat");
        check("R3 flat literal", 0, 0);

        // R4/R5: runs of two, edge equals earlier bit => late everywhere
        pat = 8'b1100_1100;
        step(pat, pat, pat, pat, 1'b1, "R4 prime");
        step(pat, pat, pat, pat, 1'b1, "R4 late");
        step(pat, pat, pat, pat, 1'b1, "R4 late");
        check("R4 late literal", -4, 4);
        step(pat, ~pat, pat, pat, 1'b1, "R4 early");
        step(pat, ~pat, pat, pat, 1'b1, "R4 early");
        check("R4 early literal", 4, 4);

        // R6: one weak bit next to one crossing removes exactly that crossing
        bad = pat ^ 8'b0000_0100;
        step(pat, pat, pat, pat, 1'b1, "R6 prime");
        step(pat, pat, pat, bad, 1'b1, "R6 weak");
        step(pat, pat, pat, pat, 1'b1, "R6 weak");
        check("R6 weak literal", -3, 3);
        step(pat, pat, pat, bad, 1'b0, "R7 weak plain");
        step(pat, pat, pat, pat, 1'b0, "R7 weak plain");
        check("R7 thresholds ignored", -4, 4);

        // R5/R7: alternating data, filter rejects all, plain accepts all
        pat = 8'b1010_1010;
        step(pat, ~pat, pat, pat, 1'b1, "R5 alt");
        step(pat, ~pat, pat, pat, 1'b1, "R5 alt");
        check("R5 alt literal", 0, 0);
        step(pat, ~pat, pat, pat, 1'b0, "R7 alt");
        step(pat, ~pat, pat, pat, 1'b0, "R7 alt");
        check("R7 alt literal", 8, 8);

        // R2/R8: long sweep, sparse threshold errors, mode toggling
        for (int k = 0; k < 4000; k++) begin
            logic [W-1:0] d, e, p, n;
            d = W'($urandom);
            if (k[0]) d = d & W'($urandom) | (d & (d << 1));
            e = W'($urandom);
            p = d ^ (W'($urandom) & W'($urandom) & W'($urandom));
            n = d ^ (W'($urandom) & W'($urandom) & W'($urandom));
            step(d, e, p, n, (k % 7) != 3, "R8 sweep");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule